// File: doc/BRIEF.md
# Interrupt Routing Unit with Mailbox

This unit gathers 64 level-sensitive interrupt sources for a single processor and sends each of them to one of a small set of processor interrupt lines. Each source has a mask bit and its own map register. The map register selects the line that the source drives. A separate set of edge-captured link inputs is held in a pending register until software clears it. A 64-bit mailbox lets another agent post message bits, and the mailbox's upper 16 bits raise one dedicated source.

Software reaches every register over a simple 64-bit register bus that uses byte addresses. Writes take effect at the clock edge. Read data appears one cycle after the address. The interrupt lines are registered, so a change at an input or in a register shows up on them one clock later.

Top module: `irq_router`

## Requirements
- R1: After reset the mask register reads all ones, every map register reads 0, the link pending register and the mailbox read 0, and irq_o is 0.
- R2: The mask register at offset 0x000 is fully readable and writable. A mask bit at 1 keeps its source off every line, and a mask bit at 0 lets the source through.
- R3: Source i has a map register at offset 0x200 + 8*i that reads back its 3-bit value in bits 2:0. Value 0, 1 or 2 routes the source to irq_o[0], irq_o[1] or irq_o[2].
- R4: A map value from 3 to 7 routes its source to no line.
- R5: irq_o[n] is a register. It is loaded every cycle with the OR of all effective sources that are asserted, unmasked and mapped to n.
- R6: A rising edge on link_i[i] sets pending bit i. The bit stays set, whatever link_i does afterwards, until it is cleared. The pending register reads at offset 0x008.
- R7: A write to offset 0x010 clears exactly the pending bits written as 1. A rising edge in the same cycle as a clear leaves that bit set. A clear while the link input stays high is not undone.
- R8: The mailbox reads at offset 0x018. A write to 0x020, or a bit on mbox_post_i, ORs bits into the mailbox. A write to 0x028 clears the bits written as 1. When a bit is set and cleared in the same cycle, the set wins.
- R9: Source 26 is active while any of mailbox bits 63:48 is set. Mailbox bits 47:0 have no effect on any source.
- R10: The effective source i is src_i[i] OR pending bit i, and for source 26 it is also ORed with the mailbox flag.
- R11: bus_rdata_o is loaded only on a read and holds its value between reads. A read of the clear or set offsets (0x010, 0x020, 0x028), or of an address with no register, returns 0.
- R12: A write to the pending register offset 0x008 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid one cycle after a read |
| src_i | input | 64 | Level interrupt sources |
| link_i | input | 64 | Link interrupt inputs, captured on rising edge |
| mbox_post_i | input | 64 | Mailbox set bits from another agent |
| irq_o | output | 3 | Processor interrupt lines |

## Verification
The hardest situations to reach are the collisions in one cycle: a link edge arriving in the same cycle as a clear write for that bit, and a posted mailbox bit landing in the same cycle as a clear of the whole mailbox. The stimulus reaches them by driving the side input and the bus write at the same falling edge, so that both are sampled at one rising edge. A behavioural model that updates on every clock then confirms that the set survives. The model also follows the mailbox flag through the mask and map to the line outputs. The mailbox is checked with only its low bits set and then with a high bit set.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // byte offsets of the register window
  localparam int unsigned OFF_MASK     = 32'h000;
  localparam int unsigned OFF_PEND     = 32'h008;
  localparam int unsigned OFF_PCLR     = 32'h010;
  localparam int unsigned OFF_MBOX     = 32'h018;
  localparam int unsigned OFF_MSET     = 32'h020;
  localparam int unsigned OFF_MCLR     = 32'h028;
  localparam int unsigned OFF_MAP_BASE = 32'h200;
  localparam int unsigned MAP_STRIDE   = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND,
    SEL_PCLR,
    SEL_MBOX,
    SEL_MSET,
    SEL_MCLR,
    SEL_MAP
  } reg_sel_e;

endpackage

// File: rtl/irq_link_latch.sv
module irq_link_latch #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] link_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] prev_q, prev_d;
  logic [N-1:0] pend_q, pend_d;

  always_comb begin
    rise_o = link_i & ~prev_q;
    prev_d = link_i;
    // a fresh edge overrides a clear of the same bit
    pend_d = (pend_q & ~clr_i) | rise_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_mailbox.sv
module irq_mailbox #(
  parameter int W    = 64,
  parameter int HI_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] mbox_o,
  output logic         hi_any_o
);

  localparam int LO_W = W - HI_W;

  logic [W-1:0] mbox_q, mbox_d;

  always_comb begin
    mbox_d = (mbox_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mbox_q <= '0;
    else         mbox_q <= mbox_d;
  end

  assign mbox_o   = mbox_q;
  assign hi_any_o = |mbox_q[W-1:LO_W];

endmodule

// File: rtl/irq_map_table.sv
module irq_map_table #(
  parameter int NSRC = 64,
  parameter int NOUT = 3,
  parameter int MAPW = 3,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [MAPW-1:0]  wr_val_i,
  output logic [MAPW-1:0]  rd_val_o,
  input  logic [NSRC-1:0]  act_i,
  output logic [NOUT-1:0]  line_o
);

  logic [MAPW-1:0] map_q [NSRC];
  logic [MAPW-1:0] map_d [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      if (wr_en_i && (idx_i == IDX_W'(g))) map_d[g] = wr_val_i;
      else                                 map_d[g] = map_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_q[g] <= '0;
      else         map_q[g] <= map_d[g];
    end
  end

  assign rd_val_o = map_q[idx_i];

  // values at or above NOUT select no line
  for (genvar n = 0; n < NOUT; n++) begin : g_line
    always_comb begin
      line_o[n] = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        if (act_i[i] && (map_q[i] == MAPW'(n))) line_o[n] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int DW       = 64,
  parameter int NOUT     = 3,
  parameter int MAPW     = 3,
  parameter int ADDR_W   = 12,
  parameter int MBOX_SRC = 26,
  parameter int MBOX_HI  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [NSRC-1:0]   src_i,
  input  logic [NSRC-1:0]   link_i,
  input  logic [DW-1:0]     mbox_post_i,
  output logic [NOUT-1:0]   irq_o
);

  localparam int IDX_W   = $clog2(NSRC);
  localparam int MAP_END = OFF_MAP_BASE + NSRC * MAP_STRIDE;
  localparam int SHIFT   = $clog2(MAP_STRIDE);

  // reset: asserted at once, released after two clock edges
  logic rst_s1_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_n    <= rst_s1_q;
    end
  end

  // address decode
  reg_sel_e          reg_sel;
  logic              map_win;
  logic [ADDR_W-1:0] map_off;
  logic [IDX_W-1:0]  map_idx;
  logic              wr_en, rd_en;

  always_comb begin
    map_win = ({1'b0, bus_addr_i} >= (ADDR_W+1)'(OFF_MAP_BASE)) &&
              ({1'b0, bus_addr_i} <  (ADDR_W+1)'(MAP_END));
    map_off = bus_addr_i - ADDR_W'(OFF_MAP_BASE);
    map_idx = IDX_W'(map_off >> SHIFT);
    wr_en   = bus_sel_i && bus_we_i;
    rd_en   = bus_sel_i && !bus_we_i;
    if      (bus_addr_i == ADDR_W'(OFF_MASK)) reg_sel = SEL_MASK;
    else if (bus_addr_i == ADDR_W'(OFF_PEND)) reg_sel = SEL_PEND;
    else if (bus_addr_i == ADDR_W'(OFF_PCLR)) reg_sel = SEL_PCLR;
    else if (bus_addr_i == ADDR_W'(OFF_MBOX)) reg_sel = SEL_MBOX;
    else if (bus_addr_i == ADDR_W'(OFF_MSET)) reg_sel = SEL_MSET;
    else if (bus_addr_i == ADDR_W'(OFF_MCLR)) reg_sel = SEL_MCLR;
    else if (map_win)                         reg_sel = SEL_MAP;
    else                                      reg_sel = SEL_NONE;
  end

  // mask register
  logic [NSRC-1:0] mask_q, mask_d;
  always_comb begin
    if (wr_en && (reg_sel == SEL_MASK)) mask_d = bus_wdata_i[NSRC-1:0];
    else                                mask_d = mask_q;
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  // link pending
  logic [NSRC-1:0] pclr_vec, link_rise, pend;
  assign pclr_vec = (wr_en && (reg_sel == SEL_PCLR)) ? bus_wdata_i[NSRC-1:0] : '0;

  irq_link_latch #(.N(NSRC)) u_link (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .link_i (link_i),
    .clr_i  (pclr_vec),
    .rise_o (link_rise),
    .pend_o (pend)
  );

  // mailbox
  logic [DW-1:0] mset_vec, mclr_vec, mbox;
  logic          mbox_hi_any;
  always_comb begin
    mset_vec = mbox_post_i;
    if (wr_en && (reg_sel == SEL_MSET)) mset_vec = mset_vec | bus_wdata_i;
    mclr_vec = (wr_en && (reg_sel == SEL_MCLR)) ? bus_wdata_i : '0;
  end

  irq_mailbox #(.W(DW), .HI_W(MBOX_HI)) u_mbox (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .set_i    (mset_vec),
    .clr_i    (mclr_vec),
    .mbox_o   (mbox),
    .hi_any_o (mbox_hi_any)
  );

  // effective sources and routing
  logic [NSRC-1:0] eff, act;
  always_comb begin
    eff           = src_i | pend;
    eff[MBOX_SRC] = eff[MBOX_SRC] | mbox_hi_any;
    act           = eff & ~mask_q;
  end

  logic [MAPW-1:0] map_rd;
  logic [NOUT-1:0] line;

  irq_map_table #(.NSRC(NSRC), .NOUT(NOUT), .MAPW(MAPW)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en && (reg_sel == SEL_MAP)),
    .idx_i    (map_idx),
    .wr_val_i (bus_wdata_i[MAPW-1:0]),
    .rd_val_o (map_rd),
    .act_i    (act),
    .line_o   (line)
  );

  logic [NOUT-1:0] irq_q, irq_d;
  assign irq_d = line;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // read path, loaded only on a read
  logic [DW-1:0] rd_val, rdata_q, rdata_d;
  always_comb begin
    unique case (reg_sel)
      SEL_MASK: rd_val = DW'(mask_q);
      SEL_PEND: rd_val = DW'(pend);
      SEL_MBOX: rd_val = mbox;
      SEL_MAP:  rd_val = DW'(map_rd);
      default:  rd_val = '0;
    endcase
    rdata_d = rd_en ? rd_val : rdata_q;
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC = 64,
  parameter int DW   = 64,
  parameter int NOUT = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] mask_q,
  input logic [NOUT-1:0] irq_o,
  input logic [NSRC-1:0] link_rise,
  input logic [NSRC-1:0] pend,
  input logic [DW-1:0]   mset,
  input logic [DW-1:0]   mclr,
  input logic [DW-1:0]   mbox,
  input logic            rd_en,
  input logic [DW-1:0]   rdata
);

  // R2
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |=> (irq_o == '0));

  // R6
  link_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_rise != '0) |=> ((pend & $past(link_rise)) == $past(link_rise)));

  // R8
  mbox_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mset != '0) |=> ((mbox & $past(mset)) == $past(mset)));

  // R8
  mbox_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mclr & ~mset) != '0) |=> ((mbox & $past(mclr & ~mset)) == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .DW(DW), .NOUT(NOUT)) u_irq_router_chk (
  .clk       (clk_i),
  .rst_n     (rst_n),
  .mask_q    (mask_q),
  .irq_o     (irq_o),
  .link_rise (link_rise),
  .pend      (pend),
  .mset      (mset_vec),
  .mclr      (mclr_vec),
  .mbox      (mbox),
  .rd_en     (rd_en),
  .rdata     (bus_rdata_o)
);

// File: tb/test_irq_router.sv
module test_irq_router;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [63:0] bus_wdata_i = '0;
  logic [63:0] bus_rdata_o;
  logic [63:0] src_i = '0;
  logic [63:0] link_i = '0;
  logic [63:0] mbox_post_i = '0;
  logic [2:0]  irq_o;

  irq_router i_irq_router (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit cmp_en  = 1'b0;
  bit done    = 1'b0;

  // behavioural reference model
  logic [63:0] m_mask, m_pend, m_prev, m_mbox, m_rdata;
  int          m_map [64];
  logic [2:0]  m_irq;

  function automatic logic [63:0] m_read(input logic [11:0] a);
    int ia;
    ia = int'(a);
    if (ia == 'h000) return m_mask;
    if (ia == 'h008) return m_pend;
    if (ia == 'h018) return m_mbox;
    if (ia >= 'h200 && ia < 'h400) return 64'(m_map[(ia - 'h200) / 8]);
    return 64'd0;
  endfunction

  always @(posedge clk_i) begin
    logic [63:0] eff, nrise;
    logic [2:0]  nirq;
    if (!rst_ni) begin
      m_mask = '1; m_pend = '0; m_prev = '0; m_mbox = '0; m_rdata = '0; m_irq = '0;
      for (int i = 0; i < 64; i++) m_map[i] = 0;
    end else begin
      eff = src_i | m_pend;
      if (m_mbox[63:48] != 0) eff[26] = 1'b1;
      nirq = '0;
      for (int i = 0; i < 64; i++)
        if (eff[i] && !m_mask[i] && m_map[i] < 3) nirq[m_map[i]] = 1'b1;
      m_irq = nirq;
      if (bus_sel_i && !bus_we_i) m_rdata = m_read(bus_addr_i);
      nrise = link_i & ~m_prev;
      m_prev = link_i;
      if (bus_sel_i && bus_we_i && bus_addr_i == 12'h010) m_pend = m_pend & ~bus_wdata_i;
      m_pend = m_pend | nrise;
      if (bus_sel_i && bus_we_i && bus_addr_i == 12'h028) m_mbox = m_mbox & ~bus_wdata_i;
      m_mbox = m_mbox | mbox_post_i;
      if (bus_sel_i && bus_we_i && bus_addr_i == 12'h020) m_mbox = m_mbox | bus_wdata_i;
      if (bus_sel_i && bus_we_i && bus_addr_i == 12'h000) m_mask = bus_wdata_i;
      if (bus_sel_i && bus_we_i && int'(bus_addr_i) >= 'h200 && int'(bus_addr_i) < 'h400)
        m_map[(int'(bus_addr_i) - 'h200) / 8] = int'(bus_wdata_i[2:0]);
    end
  end

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en) begin
      check(64'(irq_o), 64'(m_irq), "R5 irq model");
      check(bus_rdata_o, m_rdata, "R11 rdata model");
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    cyc();
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    cyc();
    bus_sel_i = 1'b0;
    check(bus_rdata_o, exp, tag);
  endtask

  function automatic logic [11:0] map_addr(input int i);
    return 12'('h200 + 8 * i);
  endfunction

  initial begin
    logic [63:0] mk;
    cyc(3);
    rst_ni = 1'b1;
    cyc(4);
    cmp_en = 1'b1;

    // R1 reset state
    rd(12'h000, '1, "R1 mask reset");
    rd(map_addr(5), 64'd0, "R1 map reset");
    rd(12'h008, 64'd0, "R1 pend reset");
    rd(12'h018, 64'd0, "R1 mbox reset");
    check(64'(irq_o), 64'd0, "R1 irq reset");

    // R2 R3 R5 routing to three lines
    mk = ~((64'd1 << 3) | (64'd1 << 10) | (64'd1 << 40));
    wr(12'h000, mk);
    wr(map_addr(10), 64'd1);
    wr(map_addr(40), 64'd2);
    src_i = (64'd1 << 3) | (64'd1 << 10) | (64'd1 << 40);
    cyc();
    check(64'(irq_o), 64'b111, "R5 all lines");
    rd(12'h000, mk, "R2 mask readback");
    rd(map_addr(40), 64'd2, "R3 map readback");

    // R2 masking one source
    mk = mk | (64'd1 << 10);
    wr(12'h000, mk);
    cyc();
    check(64'(irq_o), 64'b101, "R2 masked src");

    // R4 out-of-range map values
    wr(map_addr(3), 64'd5);
    cyc();
    check(64'(irq_o), 64'b100, "R4 map 5");
    wr(map_addr(3), 64'd3);
    cyc();
    check(64'(irq_o), 64'b100, "R4 map 3");
    rd(map_addr(3), 64'd3, "R3 map 3 readback");
    src_i = '0;
    cyc();
    check(64'(irq_o), 64'd0, "R5 sources low");

    // R6 R10 link capture
    mk = mk & ~(64'd1 << 50);
    wr(12'h000, mk);
    link_i[50] = 1'b1;
    cyc(2);
    check(64'(irq_o), 64'b001, "R10 pending routed");
    rd(12'h008, 64'd1 << 50, "R6 pend set");
    link_i[50] = 1'b0;
    cyc();
    rd(12'h008, 64'd1 << 50, "R6 pend held");
    wr(12'h010, 64'd1 << 50);
    rd(12'h008, 64'd0, "R7 pend cleared");

    // R7 clear while link stays high
    link_i[50] = 1'b1;
    cyc();
    wr(12'h010, 64'd1 << 50);
    rd(12'h008, 64'd0, "R7 no re-capture");

    // R7 edge and clear in one cycle
    link_i[51] = 1'b1;
    wr(12'h010, 64'd1 << 51);
    rd(12'h008, 64'd1 << 51, "R7 edge wins");

    // R12 write to pending is ignored
    wr(12'h008, '1);
    rd(12'h008, 64'd1 << 51, "R12 pend write ignored");
    link_i = '0;
    wr(12'h010, '1);
    rd(12'h008, 64'd0, "R7 clear all");

    // R8 R9 mailbox
    mk = mk & ~(64'd1 << 26);
    wr(12'h000, mk);
    mbox_post_i = 64'hFF;
    cyc();
    mbox_post_i = '0;
    rd(12'h018, 64'hFF, "R8 post");
    check(64'(irq_o), 64'd0, "R9 low bits no irq");
    wr(12'h020, 64'd1 << 60);
    cyc();
    check(64'(irq_o), 64'b001, "R9 high bit irq");
    rd(12'h018, 64'hFF | (64'd1 << 60), "R8 bus set");
    wr(12'h028, '1);
    rd(12'h018, 64'd0, "R8 clear all");
    check(64'(irq_o), 64'd0, "R9 flag off");

    // R8 set wins over clear
    mbox_post_i = 64'd1 << 49;
    wr(12'h028, '1);
    mbox_post_i = '0;
    rd(12'h018, 64'd1 << 49, "R8 set wins");
    check(64'(irq_o), 64'b001, "R9 bit 49 irq");

    // R11 reads of write-only and empty addresses
    rd(12'h010, 64'd0, "R11 pclr reads 0");
    rd(12'h028, 64'd0, "R11 mclr reads 0");
    rd(12'h100, 64'd0, "R11 hole reads 0");
    cyc(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule